// File: doc/BRIEF.md
# Phase-continuous FSK modulator

This block turns a serial NRZ bit stream into a digital binary-FSK waveform for a 1200 bit/s Bell-202-style link. A numerically controlled oscillator advances a phase accumulator once per enable pulse from a 460.8 kHz reference. The step size is picked from the present data bit: a 1 (mark) gives a 1200 Hz tone and a 0 (space) gives a 2200 Hz tone. The accumulator is never reloaded when the bit changes, so the waveform has no phase jump at bit boundaries. At 460.8 kHz one bit lasts 384 ticks, which is about 833 µs.

Each new phase is mapped to a signed sample with a symmetric trapezoidal shape, and the sample is passed to an external DAC. The shape has flat tops and bottoms joined by linear ramps. Because the ramps always cover the same fraction of a period, the space tone's edges are about 1.8 times steeper than the mark tone's. While the active-low send request is released, the accumulator is returned to zero phase and the output stays at mid-scale (zero).

The sample is a continuous stream at the tick rate and has no valid/ready handshake. A consumer cannot apply back-pressure, so it must take each sample in the tick in which it appears. The data bit and the send request are plain level inputs that are sampled on ticks.

Top module: `fsk_modulator`

## Requirements
- R1: After reset the sample output is 0 and the phase is zero.
- R2: On a tick with `rts_n` low and `txd` 1, the 16-bit phase advances by 171, which is round(65536·1200/460800).
- R3: On a tick with `rts_n` low and `txd` 0, the phase advances by 313, which is round(65536·2200/460800).
- R4: The step is chosen from `txd` on each tick, and the phase carries over unchanged across a change of `txd`. At a bit change, consecutive samples therefore differ by at most 5.
- R5: A tick with `rts_n` high sets the phase to zero and makes the sample 0 from that tick on. The next active tick starts again from zero phase.
- R6: Without a tick, the phase and the sample hold their values whatever `txd` and `rts_n` do.
- R7: The shape is defined with s = (phase + 8192) mod 65536, segment = s[15:14] and L = s[13:6]. Segment 0 gives L−128, segment 1 gives +127, segment 2 gives 127−L and segment 3 gives −127. Any result of −128 is replaced by −127. The sample shows the shape of the phase as updated at the same tick.
- R8: The sample always stays within −127..+127. It reaches both limits and stays flat at +127 for about a quarter of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at the 460.8 kHz reference rate |
| txd | input | 1 | NRZ data bit: 1 = mark, 0 = space |
| rts_n | input | 1 | Active-low send request |
| sample | output | 8 | Signed trapezoidal sample, 0 = mid-scale |

## Verification
Four behaviours are checked by the assertions on every cycle: the phase step on each active tick is exactly the mark or the space increment for the present bit, a released send request returns the phase and the sample to zero, nothing moves between ticks, and the sample never reaches the most negative code. The bench scenarios cover what needs a whole waveform to show. It compares every sample against an independent shape model for each tone, and it checks the small sample change across bit switches. It also checks the length of the flat top and the restart from zero phase after an idle interval.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  typedef enum logic [1:0] {
    SEG_RISE = 2'd0,
    SEG_HIGH = 2'd1,
    SEG_FALL = 2'd2,
    SEG_LOW  = 2'd3
  } trap_seg_e;

  // round(2^acc_bits * f_tone / f_ref)
  function automatic logic [63:0] tone_step(input int unsigned acc_bits,
                                            input int unsigned f_tone,
                                            input int unsigned f_ref);
    logic [63:0] num;
    num = (64'd2 << acc_bits) * 64'(f_tone) + 64'(f_ref);
    return num / (64'd2 * 64'(f_ref));
  endfunction

endpackage

// File: rtl/fsk_tone_sel.sv
module fsk_tone_sel #(
  parameter int unsigned PHASE_W    = 16,
  parameter int unsigned F_REF_HZ   = 460800,
  parameter int unsigned F_MARK_HZ  = 1200,
  parameter int unsigned F_SPACE_HZ = 2200
) (
  input  logic               bit_in,
  output logic [PHASE_W-1:0] step
);
  localparam logic [PHASE_W-1:0] STEP_MARK =
    PHASE_W'(fsk_mod_pkg::tone_step(PHASE_W, F_MARK_HZ, F_REF_HZ));
  localparam logic [PHASE_W-1:0] STEP_SPACE =
    PHASE_W'(fsk_mod_pkg::tone_step(PHASE_W, F_SPACE_HZ, F_REF_HZ));

  always_comb begin
    step = bit_in ? STEP_MARK : STEP_SPACE;
  end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] phase_nxt
);
  always_comb begin
    phase_nxt = run ? phase + step : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= phase_nxt;
  end
endmodule

// File: rtl/fsk_trap_shaper.sv
module fsk_trap_shaper #(
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic [PHASE_W-1:0]         phase,
  output logic signed [SAMPLE_W-1:0] level
);
  import fsk_mod_pkg::*;

  localparam int unsigned LVL_SHIFT = PHASE_W - 2 - SAMPLE_W;
  localparam logic [PHASE_W-1:0] EIGHTH = PHASE_W'(1) << (PHASE_W - 3);
  localparam logic signed [SAMPLE_W-1:0] PEAK_P = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] PEAK_N = {1'b1, {(SAMPLE_W-2){1'b0}}, 1'b1};
  localparam logic signed [SAMPLE_W-1:0] MOST_N = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [PHASE_W-1:0]         shifted;
  trap_seg_e                  seg;
  logic [SAMPLE_W-1:0]        lvl;
  logic signed [SAMPLE_W-1:0] rise, fall, raw;

  always_comb begin
    shifted = phase + EIGHTH;
    seg     = trap_seg_e'(shifted[PHASE_W-1 -: 2]);
    lvl     = SAMPLE_W'(shifted[PHASE_W-3:0] >> LVL_SHIFT);
    rise    = {~lvl[SAMPLE_W-1], lvl[SAMPLE_W-2:0]};
    fall    = ~rise;
    case (seg)
      SEG_RISE: raw = rise;
      SEG_HIGH: raw = PEAK_P;
      SEG_FALL: raw = fall;
      default:  raw = PEAK_N;
    endcase
    level = (raw == MOST_N) ? PEAK_N : raw;
  end
endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator #(
  parameter int unsigned PHASE_W    = 16,
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned F_REF_HZ   = 460800,
  parameter int unsigned F_MARK_HZ  = 1200,
  parameter int unsigned F_SPACE_HZ = 2200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       txd,
  input  logic                       rts_n,
  output logic signed [SAMPLE_W-1:0] sample
);
  logic [PHASE_W-1:0]         step;
  logic [PHASE_W-1:0]         phase_q;
  logic [PHASE_W-1:0]         phase_nxt;
  logic signed [SAMPLE_W-1:0] shaped;

  fsk_tone_sel #(
    .PHASE_W(PHASE_W), .F_REF_HZ(F_REF_HZ),
    .F_MARK_HZ(F_MARK_HZ), .F_SPACE_HZ(F_SPACE_HZ)
  ) u_tone (
    .bit_in(txd),
    .step  (step)
  );

  fsk_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (!rts_n),
    .step     (step),
    .phase    (phase_q),
    .phase_nxt(phase_nxt)
  );

  fsk_trap_shaper #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_shape (
    .phase(phase_nxt),
    .level(shaped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sample <= '0;
    else if (tick) sample <= shaped;
  end
endmodule

// File: rtl/fsk_mod_chk.sv
module fsk_mod_chk #(
  parameter int unsigned PHASE_W    = 16,
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned F_REF_HZ   = 460800,
  parameter int unsigned F_MARK_HZ  = 1200,
  parameter int unsigned F_SPACE_HZ = 2200
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       txd,
  input logic                       rts_n,
  input logic [PHASE_W-1:0]         phase,
  input logic signed [SAMPLE_W-1:0] sample
);
  localparam logic [PHASE_W-1:0] INC_M =
    PHASE_W'(fsk_mod_pkg::tone_step(PHASE_W, F_MARK_HZ, F_REF_HZ));
  localparam logic [PHASE_W-1:0] INC_S =
    PHASE_W'(fsk_mod_pkg::tone_step(PHASE_W, F_SPACE_HZ, F_REF_HZ));
  localparam logic signed [SAMPLE_W-1:0] MOST_N = {1'b1, {(SAMPLE_W-1){1'b0}}};

  p_mark_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !rts_n && txd |=> PHASE_W'(phase - $past(phase)) == INC_M);

  p_space_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !rts_n && !txd |=> PHASE_W'(phase - $past(phase)) == INC_S);

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && rts_n |=> phase == '0 && sample == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase) && $stable(sample));

  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample != MOST_N);
endmodule

bind fsk_modulator fsk_mod_chk #(
  .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .F_REF_HZ(F_REF_HZ),
  .F_MARK_HZ(F_MARK_HZ), .F_SPACE_HZ(F_SPACE_HZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .rts_n(rts_n),
  .phase(phase_q), .sample(sample)
);

// File: tb/test_fsk_modulator.sv
module test_fsk_modulator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic txd = 1'b1;
  logic rts_n = 1'b1;
  logic signed [7:0] sample;

  int n_checks = 0;
  int n_fail = 0;
  int m_phase = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fsk_modulator i_fsk_modulator (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .rts_n(rts_n),
    .sample(sample)
  );

  function automatic int shape(input int p);
    int s, q, l, v;
    s = (p + 8192) % 65536;
    q = s / 16384;
    l = (s % 16384) / 64;
    case (q)
      0: v = l - 128;
      1: v = 127;
      2: v = 127 - l;
      default: v = -127;
    endcase
    if (v < -127) v = -127;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one tick; returns at the following negedge with the sample updated
  task automatic do_tick(input logic b, input logic r);
    txd = b;
    rts_n = r;
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    if (r) m_phase = 0;
    else   m_phase = (m_phase + (b ? 171 : 313)) % 65536;
  endtask

  task automatic t_reset;
    chk("R1 reset sample", int'(sample), 0);
    do_tick(1'b1, 1'b1);
    chk("R1 idle after reset", int'(sample), 0);
  endtask

  task automatic t_mark;
    do_tick(1'b1, 1'b1);
    do_tick(1'b1, 1'b0);
    chk("R2 first mark sample", int'(sample), 2);
    for (int i = 1; i < 384; i++) begin
      do_tick(1'b1, 1'b0);
      chk("R2 mark tone", int'(sample), shape(m_phase));
    end
    chk("R2 phase after one bit", m_phase, 128);
  endtask

  task automatic t_space;
    do_tick(1'b0, 1'b1);
    do_tick(1'b0, 1'b0);
    chk("R3 first space sample", int'(sample), 4);
    for (int i = 1; i < 384; i++) begin
      do_tick(1'b0, 1'b0);
      chk("R3 space tone", int'(sample), shape(m_phase));
    end
  endtask

  task automatic t_continuity;
    logic b;
    int prev, d;
    b = 1'b1;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 384; i++) begin
        prev = int'(sample);
        do_tick(b, 1'b0);
        chk("R4 alternating bits", int'(sample), shape(m_phase));
        if (i == 0 && k > 0) begin
          d = int'(sample) - prev;
          if (d < 0) d = -d;
          chk("R4 no jump at bit change", int'(d <= 5), 1);
        end
      end
      b = ~b;
    end
  endtask

  task automatic t_no_tick;
    int held;
    do_tick(1'b0, 1'b0);
    held = int'(sample);
    for (int i = 0; i < 20; i++) begin
      txd = i[0];
      rts_n = i[1];
      @(negedge clk);
    end
    chk("R6 sample held without tick", int'(sample), held);
    do_tick(1'b1, 1'b0);
    chk("R6 phase kept across pause", int'(sample), shape(m_phase));
  endtask

  task automatic t_release;
    do_tick(1'b1, 1'b0);
    do_tick(1'b1, 1'b1);
    chk("R5 idle sample", int'(sample), 0);
    do_tick(1'b0, 1'b1);
    chk("R5 stays idle", int'(sample), 0);
    do_tick(1'b1, 1'b0);
    chk("R5 restart from zero phase", int'(sample), 2);
  endtask

  task automatic t_flat;
    int mx, mn, ntop, etop;
    do_tick(1'b1, 1'b1);
    mx = -999; mn = 999; ntop = 0; etop = 0;
    for (int i = 0; i < 384; i++) begin
      do_tick(1'b1, 1'b0);
      if (int'(sample) > mx) mx = int'(sample);
      if (int'(sample) < mn) mn = int'(sample);
      if (int'(sample) == 127) ntop++;
      if (shape(m_phase) == 127) etop++;
    end
    chk("R8 positive limit", mx, 127);
    chk("R8 negative limit", mn, -127);
    chk("R7 flat top length", ntop, etop);
    chk("R8 flat top near quarter", int'(ntop >= 90 && ntop <= 100), 1);
  endtask

  initial begin
    repeat (600000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mark();
    t_space();
    t_continuity();
    t_no_tick();
    t_release();
    t_flat();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule